// File: doc/BRIEF.md
# Four-Lane Integer Shift Unit

This block is the shift slice of a vector integer datapath. One operation carries two 128-bit operands, each split into four 32-bit lanes. Every lane of the value operand is shifted by the count in the same lane of the count operand. Each lane works on its own data, and all four lanes share one opcode and one count-mode select. Three shifts are available: left, arithmetic right and logical right. The fourth opcode passes the value operand through unchanged.

Counts can be read in two ways. In full-width mode the entire 32-bit lane of the count operand is an unsigned count, and any count above 31 saturates the lane. In masked mode only the five low bits of the count are used, so the count wraps modulo 32. The mode is captured with each accepted operation. A mode change therefore never affects an operation that has already been accepted.

Operations enter and leave through valid/ready handshakes. There is a single output register between the two sides, so a result appears one clock after it is accepted. When the consumer is not ready, the result is held and new input is refused.

Top module: `vec_shift_unit`

## Requirements
- R1: Lane i occupies bits [32*i+31:32*i] of in_a, in_b and out_data. Opcode 2'b00 shifts each lane of in_a left by its own count and fills the vacated low bits with zeros.
- R2: Opcode 2'b10 is a logical right shift. The vacated high bits are filled with zeros.
- R3: Opcode 2'b01 is an arithmetic right shift. The vacated high bits are filled with copies of bit 31 of the lane.
- R4: When in_mode is 1 (full-width), the whole 32-bit count is read as unsigned. A count above 31 gives 0x00000000 for opcodes 2'b00 and 2'b10. For opcode 2'b01 it gives 0xFFFFFFFF when bit 31 of the lane is set, and 0x00000000 otherwise.
- R5: When in_mode is 0 (masked), only bits [4:0] of the count are used. For example, a count of 33 acts as 1, and a count of 32 acts as 0.
- R6: An effective count of zero returns the in_a lane unchanged, for every opcode and in both modes.
- R7: Opcode 2'b11 is reserved. It returns in_a unchanged whatever the count.
- R8: An operation is accepted when in_valid and in_ready are both high. Its result appears on out_data with out_valid high after exactly one clock edge. out_valid falls after an edge where out_ready is high and nothing new is accepted.
- R9: While out_valid is high and out_ready is low, in_ready is low, and out_valid and out_data hold their values.
- R10: The count mode is taken from in_mode in the cycle of acceptance. Changing in_mode afterwards does not alter a pending result.
- R11: A synchronous active-high reset clears out_valid and out_data to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_op | input | 2 | Opcode: 00 left, 01 arithmetic right, 10 logical right, 11 pass |
| in_mode | input | 1 | Count mode: 1 full-width saturating, 0 masked to five bits |
| in_a | input | 128 | Four 32-bit values to shift |
| in_b | input | 128 | Four 32-bit counts |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Four 32-bit shifted results |

## Verification
Most faults in this block show up in one lane's data on the first result after the faulty operation is accepted. Examples are a wrong stage in the shifter, a fill bit taken from the wrong place, or a saturation flag built from the wrong count bits. The vectors use counts that differ between lanes and counts that straddle 31 and 32, so that these faults land on values that differ from the correct ones. A fault in the handshake register shows up at the ports within one or two edges: a lost or repeated result, a value that changes during a stall, or in_ready staying high while a stall holds.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

   typedef enum logic [1:0] {
      OP_SHL  = 2'b00,
      OP_SRA  = 2'b01,
      OP_SRL  = 2'b10,
      OP_PASS = 2'b11
   } shift_op_e;

   typedef enum logic {
      CNT_MASKED = 1'b0,
      CNT_FULL   = 1'b1
   } cnt_mode_e;

   // Shifter variants selectable per instance
   localparam int unsigned STYLE_LOG_STAGES = 0;
   localparam int unsigned STYLE_OPERATOR   = 1;

endpackage

// File: rtl/vshift_count_decode.sv
module vshift_count_decode #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CNT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] cnt_raw,
   input  logic              full_mode,
   output logic [CNT_W-1:0]  cnt_eff,
   output logic              cnt_sat
);

   logic upper_set;

   // Any bit above the in-range field marks an out-of-range count
   assign upper_set = |cnt_raw[DATA_W-1:CNT_W];
   assign cnt_eff   = cnt_raw[CNT_W-1:0];
   assign cnt_sat   = full_mode & upper_set;

endmodule

// File: rtl/vshift_lane.sv
module vshift_lane
   import vshift_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned STYLE  = STYLE_LOG_STAGES,
   localparam int unsigned CNT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] val,
   input  logic [CNT_W-1:0]  amt,
   input  logic              sat,
   input  shift_op_e         op,
   output logic [DATA_W-1:0] res
);

   logic              go_right;
   logic              fill_bit;
   logic [DATA_W-1:0] shifted;

   assign go_right = (op == OP_SRA) || (op == OP_SRL);
   assign fill_bit = (op == OP_SRA) & val[DATA_W-1];

   generate
      if (STYLE == STYLE_LOG_STAGES) begin : g_log
         logic [CNT_W:0][DATA_W-1:0] stage;
         assign stage[0] = val;
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            localparam int unsigned S = 1 << k;
            logic [DATA_W-1:0] to_left;
            logic [DATA_W-1:0] to_right;
            assign to_left  = {stage[k][DATA_W-1-S:0], {S{1'b0}}};
            assign to_right = {{S{fill_bit}}, stage[k][DATA_W-1:S]};
            assign stage[k+1] = !amt[k]  ? stage[k] :
                                go_right ? to_right : to_left;
         end
         assign shifted = stage[CNT_W];
      end else if (STYLE == STYLE_OPERATOR) begin : g_op
         logic signed [DATA_W-1:0] sval;
         assign sval = val;
         always_comb begin
            if (op == OP_SRA)      shifted = sval >>> amt;
            else if (op == OP_SRL) shifted = val >> amt;
            else                   shifted = val << amt;
         end
      end else begin : g_bad
         $error("vshift_lane: unknown STYLE %0d", STYLE);
         assign shifted = val;
      end
   endgenerate

   always_comb begin
      if (op == OP_PASS) res = val;
      else if (sat)      res = {DATA_W{fill_bit}};
      else               res = shifted;
   end

endmodule

// File: rtl/vshift_out_reg.sv
module vshift_out_reg #(
   parameter int unsigned WIDTH = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             up_valid,
   output logic             up_ready,
   input  logic [WIDTH-1:0] up_data,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic [WIDTH-1:0] dn_data
);

   logic take;

   assign up_ready = !dn_valid || dn_ready;
   assign take     = up_valid && up_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         dn_valid <= 1'b0;
         dn_data  <= '0;
      end else begin
         if (take) begin
            dn_valid <= 1'b1;
            dn_data  <= up_data;
         end else if (dn_ready) begin
            dn_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/vec_shift_unit.sv
module vec_shift_unit
   import vshift_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned STYLE  = STYLE_LOG_STAGES,
   localparam int unsigned CNT_W = $clog2(DATA_W),
   localparam int unsigned VEC_W = LANES * DATA_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [1:0]       in_op,
   input  logic             in_mode,
   input  logic [VEC_W-1:0] in_a,
   input  logic [VEC_W-1:0] in_b,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [VEC_W-1:0] out_data
);

   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_w
         $error("vec_shift_unit: DATA_W must be a power of two >= 2");
      end
      if (LANES < 1) begin : g_chk_l
         $error("vec_shift_unit: LANES must be at least 1");
      end
   endgenerate

   shift_op_e        op_sel;
   logic [VEC_W-1:0] lane_res;

   assign op_sel = shift_op_e'(in_op);

   // The mode enters the combinational result, so it is captured
   // together with the operation when the result is registered.
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [CNT_W-1:0] amt;
         logic             sat;

         vshift_count_decode #(.DATA_W(DATA_W)) u_dec (
            .cnt_raw  (in_b[i*DATA_W +: DATA_W]),
            .full_mode(in_mode),
            .cnt_eff  (amt),
            .cnt_sat  (sat)
         );

         vshift_lane #(.DATA_W(DATA_W), .STYLE(STYLE)) u_lane (
            .val(in_a[i*DATA_W +: DATA_W]),
            .amt(amt),
            .sat(sat),
            .op (op_sel),
            .res(lane_res[i*DATA_W +: DATA_W])
         );
      end
   endgenerate

   vshift_out_reg #(.WIDTH(VEC_W)) u_oreg (
      .clk     (clk),
      .rst     (rst),
      .up_valid(in_valid),
      .up_ready(in_ready),
      .up_data (lane_res),
      .dn_valid(out_valid),
      .dn_ready(out_ready),
      .dn_data (out_data)
   );

endmodule

// File: rtl/vec_shift_unit_chk.sv
module vec_shift_unit_chk #(
   parameter int unsigned VEC_W = 128
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic [1:0]       in_op,
   input logic [VEC_W-1:0] in_a,
   input logic [VEC_W-1:0] in_b,
   input logic             out_valid,
   input logic             out_ready,
   input logic [VEC_W-1:0] out_data
);

   // R8
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> out_valid);

   // R8
   drain_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && !in_valid) |=> !out_valid);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R9
   stall_refuse_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready && in_valid) |=> $stable(out_data));

   // R7
   reserved_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_op == 2'b11) |=> (out_data == $past(in_a)));

   // R6
   zero_count_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_b == '0) |=> (out_data == $past(in_a)));

   // R11
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

endmodule

bind vec_shift_unit vec_shift_unit_chk #(.VEC_W(VEC_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_op    (in_op),
   .in_a     (in_a),
   .in_b     (in_b),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_data (out_data)
);

// File: tb/vec_shift_unit_bench.sv
`timescale 1ns/1ps
module vec_shift_unit_bench;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic         in_ready;
   logic [1:0]   in_op;
   logic         in_mode;
   logic [127:0] in_a;
   logic [127:0] in_b;
   logic         out_valid;
   logic         out_ready;
   logic [127:0] out_data;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #4 clk = ~clk;

   vec_shift_unit u_vec_shift_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   typedef struct packed {
      logic [1:0]   op;
      logic         mode;
      logic [127:0] a;
      logic [127:0] b;
      logic [127:0] e;
   } vec_t;

   localparam int NV = 11;
   // lanes written lane3, lane2, lane1, lane0
   localparam vec_t VT [NV] = '{
      // R1 left, masked
      '{2'b00, 1'b0, 128'hFFFFFFFF_12345678_80000001_00000001,
                     128'h0000001F_00000008_00000001_00000004,
                     128'h80000000_34567800_00000002_00000010},
      // R2 logical right, masked
      '{2'b10, 1'b0, 128'hFFFFFFFF_12345678_F000000F_80000000,
                     128'h00000001_00000010_00000004_0000001F,
                     128'h7FFFFFFF_00001234_0F000000_00000001},
      // R3 arithmetic right, masked
      '{2'b01, 1'b0, 128'h87654321_7FFFFFFF_F000000F_80000000,
                     128'h00000008_0000001E_00000004_0000001F,
                     128'hFF876543_00000001_FF000000_FFFFFFFF},
      // R5 masked wrap of large counts
      '{2'b00, 1'b0, 128'hABCD0123_000000F0_00000001_00000001,
                     128'hFFFFFFE0_00000104_00000020_00000021,
                     128'hABCD0123_00000F00_00000001_00000002},
      // R4 full-width left saturation
      '{2'b00, 1'b1, 128'h00000005_00000001_FFFFFFFF_00000001,
                     128'h80000000_0000001F_00000020_00000021,
                     128'h00000000_80000000_00000000_00000000},
      // R4 full-width arithmetic saturation to sign
      '{2'b01, 1'b1, 128'h80000001_C0000000_7FFFFFFF_80000000,
                     128'hFFFFFFFF_00000001_00000064_00000020,
                     128'hFFFFFFFF_E0000000_00000000_FFFFFFFF},
      // R4 full-width logical saturation
      '{2'b10, 1'b1, 128'h12345678_80000000_FFFFFFFF_FFFFFFFF,
                     128'h00000004_00000100_0000001F_00000020,
                     128'h01234567_00000000_00000001_00000000},
      // R7 reserved opcode
      '{2'b11, 1'b1, 128'hFFFFFFFF_80000000_01234567_DEADBEEF,
                     128'h00000001_00000000_00000028_00000005,
                     128'hFFFFFFFF_80000000_01234567_DEADBEEF},
      // R6 zero effective count, masked
      '{2'b01, 1'b0, 128'h00000000_FFFFFFFF_12345678_80000000,
                     128'h00000040_00000000_00000020_00000000,
                     128'h00000000_FFFFFFFF_12345678_80000000},
      // R6 zero count, full-width logical right
      '{2'b10, 1'b1, 128'hCAFEF00D_00000001_FFFFFFFF_80000000,
                     128'h0,
                     128'hCAFEF00D_00000001_FFFFFFFF_80000000},
      // R6 zero count, full-width left
      '{2'b00, 1'b1, 128'h13579BDF_2468ACE0_FFFFFFFF_00000001,
                     128'h0,
                     128'h13579BDF_2468ACE0_FFFFFFFF_00000001}
   };

   string tag [NV] = '{"R1", "R2", "R3", "R5", "R4", "R4", "R4",
                       "R7", "R6", "R6", "R6"};

   task automatic check(input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic mode,
                        input logic [127:0] a, input logic [127:0] b);
      in_valid = 1'b1;
      in_op    = op;
      in_mode  = mode;
      in_a     = a;
      in_b     = b;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_op = 2'b00; in_mode = 1'b0;
      in_a = '0; in_b = '0; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 out_valid after reset", {127'b0, out_valid}, 128'h0);
      check("R11 out_data after reset", out_data, 128'h0);
      check("R9 in_ready idle", {127'b0, in_ready}, 128'h1);
      rst = 1'b0;
      @(negedge clk);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         drive(VT[i].op, VT[i].mode, VT[i].a, VT[i].b);
         @(negedge clk);
         check({tag[i], " R8 valid"}, {127'b0, out_valid}, 128'h1);
         check({tag[i], " data"}, out_data, VT[i].e);
         in_valid = 1'b0;
         @(negedge clk);
         check("R8 drain", {127'b0, out_valid}, 128'h0);
      end

      // R9 / R10: stall, then change mode on the next offered op
      out_ready = 1'b0;
      drive(2'b00, 1'b1, {4{32'h00000001}}, {4{32'h00000028}});
      @(negedge clk);
      check("R4 stalled result", out_data, 128'h0);
      check("R9 in_ready low in stall", {127'b0, in_ready}, 128'h0);
      drive(2'b00, 1'b0, {4{32'h00000001}}, {4{32'h00000028}});
      @(negedge clk);
      check("R10 pending result kept after mode change", out_data, 128'h0);
      check("R9 out_valid held", {127'b0, out_valid}, 128'h1);
      out_ready = 1'b1;
      @(negedge clk);
      check("R5 masked count 40 acts as 8", out_data, {4{32'h00000100}});
      in_valid = 1'b0;
      @(negedge clk);
      check("R8 drained after stall", {127'b0, out_valid}, 128'h0);

      // R11 reset while a result is held
      out_ready = 1'b0;
      drive(2'b11, 1'b0, {4{32'hA5A5A5A5}}, '0);
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 pass held", out_data, {4{32'hA5A5A5A5}});
      rst = 1'b1;
      @(negedge clk);
      check("R11 mid-run out_valid", {127'b0, out_valid}, 128'h0);
      check("R11 mid-run out_data", out_data, 128'h0);
      rst = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule